// File: doc/BRIEF.md
# Speculative Line Fill Buffer

This block sits on the miss path between a first-level cache and the next cache level. Any line that a load or an instruction fetch misses on is fetched into a small fully associative holding buffer and is kept out of the first-level cache. Later requests to the same line are answered from the buffer or are merged onto the outstanding entry, so no second request goes downstream.

A buffered line reaches the first-level cache only when one of the loads that use it commits. A squash withdraws a load. A line that loses all its loads before a commit is dropped without being installed. Wrong-path execution therefore leaves the observable cache unchanged. The core drives one bit per in-flight load tag on the commit and squash inputs, and the block installs at most one line per cycle on its install port.

Top module: `fsb_fill_buffer`

## Requirements
- R1: A lookup that matches no entry while an entry is free takes that entry. One cycle later the block issues exactly one downstream request that carries the line address and the entry index as its id. The returned line is not installed when it arrives.
- R2: A lookup that matches an entry whose data is present returns, one cycle later, the entry's full line and the requesting tag on the hit port. No downstream request is issued for it.
- R3: A lookup that matches an entry still waiting for data adds its tag to that entry and issues no downstream request. When data arrives for a waiting entry, the line and its address appear on the forward port one cycle later.
- R4: A lookup that matches no entry while every entry is occupied raises the stall output in the same cycle, and the request is not taken. After an entry has been freed, the same lookup is accepted.
- R5: A commit of any tag tracked on an entry causes that entry's line and address to be installed. A commit that arrives before the data makes the install wait until the data is present. After the install the entry is free, so a later lookup of that line misses.
- R6: A squash removes its tag from the entry. An entry left with no tags and no pending install is freed and its line is never installed. If its data has not yet arrived, the entry is released when the data arrives.
- R7: At most one line is installed per cycle. When several committed entries hold data, the entry whose committing tag has the smallest value (the smaller tag is the older load) is installed first.
- R8: After reset no entry is occupied and every output is low.
- R9: Bit i of the commit and squash masks refers to load tag i. A bit for a tag that no entry tracks changes nothing: there is no install, and the buffered lines still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request for a line that missed the first-level cache |
| lk_addr_i | input | ADDR_W | Line address of the lookup |
| lk_tag_i | input | TAG_W | Load tag of the lookup |
| lk_stall_o | output | 1 | Lookup refused because the buffer is full |
| hit_valid_o | output | 1 | Hit response valid |
| hit_tag_o | output | TAG_W | Tag of the load that hit |
| hit_data_o | output | LINE_W | Line data for the hit |
| dn_req_valid_o | output | 1 | Downstream line request valid |
| dn_req_addr_o | output | ADDR_W | Requested line address |
| dn_req_id_o | output | IDX_W | Entry index that the fill must carry |
| fill_valid_i | input | 1 | Line returned from the lower level |
| fill_id_i | input | IDX_W | Entry index of the returned line |
| fill_data_i | input | LINE_W | Returned line data |
| fwd_valid_o | output | 1 | Arriving line forwarded to waiting loads |
| fwd_addr_o | output | ADDR_W | Address of the forwarded line |
| fwd_data_o | output | LINE_W | Forwarded line data |
| commit_mask_i | input | TAGS | One bit per load tag that commits this cycle |
| squash_mask_i | input | TAGS | One bit per load tag that is squashed this cycle |
| inst_valid_o | output | 1 | Install a line into the first-level cache |
| inst_addr_o | output | ADDR_W | Installed line address |
| inst_data_o | output | LINE_W | Installed line data |

## Verification
The assertions check on every cycle that a stall occurs only when every entry is occupied and nothing matched, that a matching lookup is never followed by a downstream request, and that no two entries match one address. They also check that the install selector picks one entry at most, that the entry it picks is committed and holds data, and that no other candidate has a smaller committing tag. Only the bench scenarios can show that a squashed line never reaches the install port, that a commit arriving before the data is remembered, that merged loads keep a line alive after the first load is squashed, and that freed entries really miss afterwards.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    // Lifecycle of one buffer slot
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,   // slot unused
        ENT_WAIT = 2'd1,   // request sent, data not yet returned
        ENT_HELD = 2'd2    // data present, awaiting commit or squash
    } ent_state_e;

endpackage

// File: rtl/fsb_match.sv
// Fully associative address compare plus first-free slot search.
module fsb_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 lk_addr,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr,
    input  logic [ENTRIES-1:0]                busy,
    output logic [ENTRIES-1:0]                hit_vec,
    output logic                              hit_any,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic                              free_any,
    output logic [IDX_W-1:0]                  free_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = busy[g] && (ent_addr[g] == lk_addr);
    end

    assign hit_any  = |hit_vec;
    assign free_any = ~&busy;

    // lowest index wins in both searches
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!busy[i])   free_idx = IDX_W'(i);
        end
    end

    // R1: allocation never creates a second slot for one address
    a_r1_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/fsb_age_pick.sv
// Selects the committed slot with the smallest committing tag.
module fsb_age_pick #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned KEY_W   = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ENTRIES-1:0]               cand,
    input  logic [ENTRIES-1:0][KEY_W-1:0]    key,
    output logic                             pick_any,
    output logic [IDX_W-1:0]                 pick_idx,
    output logic [ENTRIES-1:0]               pick_oh
);

    logic [KEY_W-1:0] best_key;

    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        best_key = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cand[i] && (!pick_any || key[i] < best_key)) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(i);
                best_key = key[i];
            end
        end
        pick_oh = pick_any ? (ENTRIES'(1) << pick_idx) : '0;
    end

    // R7: one install per cycle
    a_r7_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        // R7: no waiting candidate is older than the chosen one
        a_r7_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_any && cand[g]) |-> (key[pick_idx] <= key[g]));
    end

endmodule

// File: rtl/fsb_fill_buffer.sv
// Speculative line fill buffer: holds miss data until its load commits.
module fsb_fill_buffer
    import fsb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LINE_W  = 512,
    parameter int unsigned TAGS    = 16,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned TAG_W  = (TAGS > 1) ? $clog2(TAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid_i,
    input  logic [ADDR_W-1:0]    lk_addr_i,
    input  logic [TAG_W-1:0]     lk_tag_i,
    output logic                 lk_stall_o,
    output logic                 hit_valid_o,
    output logic [TAG_W-1:0]     hit_tag_o,
    output logic [LINE_W-1:0]    hit_data_o,
    output logic                 dn_req_valid_o,
    output logic [ADDR_W-1:0]    dn_req_addr_o,
    output logic [IDX_W-1:0]     dn_req_id_o,
    input  logic                 fill_valid_i,
    input  logic [IDX_W-1:0]     fill_id_i,
    input  logic [LINE_W-1:0]    fill_data_i,
    output logic                 fwd_valid_o,
    output logic [ADDR_W-1:0]    fwd_addr_o,
    output logic [LINE_W-1:0]    fwd_data_o,
    input  logic [TAGS-1:0]      commit_mask_i,
    input  logic [TAGS-1:0]      squash_mask_i,
    output logic                 inst_valid_o,
    output logic [ADDR_W-1:0]    inst_addr_o,
    output logic [LINE_W-1:0]    inst_data_o
);

    typedef struct packed {
        ent_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [LINE_W-1:0]   data;
        logic [TAGS-1:0]     owners;    // loads still tracking the line
        logic                pend;      // a tracked load has committed
        logic [TAG_W-1:0]    pend_tag;  // smallest committing tag
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 hit_v;
        logic [TAG_W-1:0]     hit_tag;
        logic [LINE_W-1:0]    hit_data;
        logic                 req_v;
        logic [ADDR_W-1:0]    req_addr;
        logic [IDX_W-1:0]     req_id;
        logic                 fwd_v;
        logic [ADDR_W-1:0]    fwd_addr;
        logic [LINE_W-1:0]    fwd_data;
        logic                 inst_v;
        logic [ADDR_W-1:0]    inst_addr;
        logic [LINE_W-1:0]    inst_data;
    } state_t;

    localparam state_t STATE_RST = '0;

    state_t st_d, st_q;

    // views of the registered slots for the search logic
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0]             busy;
    logic [ENTRIES-1:0]             cand;
    logic [ENTRIES-1:0][TAG_W-1:0]  key;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_addr[i] = st_q.ent[i].addr;
            busy[i]     = st_q.ent[i].st != ENT_FREE;
            cand[i]     = (st_q.ent[i].st == ENT_HELD) && st_q.ent[i].pend;
            key[i]      = st_q.ent[i].pend_tag;
        end
    end

    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;

    fsb_match #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W)
    ) i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr_i),
        .ent_addr (ent_addr),
        .busy     (busy),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [ENTRIES-1:0] pick_oh;

    fsb_age_pick #(
        .ENTRIES (ENTRIES),
        .KEY_W   (TAG_W)
    ) i_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .key      (key),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .pick_oh  (pick_oh)
    );

    function automatic logic [TAG_W-1:0] low_tag(input logic [TAGS-1:0] m);
        logic [TAG_W-1:0] r;
        r = '0;
        for (int t = TAGS - 1; t >= 0; t--) begin
            if (m[t]) r = TAG_W'(t);
        end
        return r;
    endfunction

    logic [TAGS-1:0] tag_oh;
    assign tag_oh     = TAGS'(1) << lk_tag_i;
    assign lk_stall_o = lk_valid_i && !hit_any && !free_any;

    always_comb begin
        logic [TAGS-1:0]  cmask;
        logic [TAG_W-1:0] ctag;

        st_d        = st_q;
        st_d.hit_v  = 1'b0;
        st_d.req_v  = 1'b0;
        st_d.fwd_v  = 1'b0;
        st_d.inst_v = 1'b0;
        cmask       = '0;
        ctag        = '0;

        // commits and squashes act on the tags held at the start of the cycle
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].st != ENT_FREE) begin
                cmask = st_q.ent[i].owners & commit_mask_i;
                if (|cmask) begin
                    ctag = low_tag(cmask);
                    if (!st_q.ent[i].pend || ctag < st_q.ent[i].pend_tag) begin
                        st_d.ent[i].pend_tag = ctag;
                    end
                    st_d.ent[i].pend = 1'b1;
                end
                st_d.ent[i].owners = st_q.ent[i].owners & ~(commit_mask_i | squash_mask_i);
            end
        end

        // returned data lands only in a slot that is waiting for it
        if (fill_valid_i && st_q.ent[fill_id_i].st == ENT_WAIT) begin
            st_d.ent[fill_id_i].st   = ENT_HELD;
            st_d.ent[fill_id_i].data = fill_data_i;
            st_d.fwd_v               = 1'b1;
            st_d.fwd_addr            = st_q.ent[fill_id_i].addr;
            st_d.fwd_data            = fill_data_i;
        end

        // one committed line per cycle moves into the first-level cache
        if (pick_any) begin
            st_d.inst_v    = 1'b1;
            st_d.inst_addr = st_q.ent[pick_idx].addr;
            st_d.inst_data = st_q.ent[pick_idx].data;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (pick_oh[i]) begin
                st_d.ent[i]    = '0;
                st_d.ent[i].st = ENT_FREE;
            end
        end

        // lookup: serve, merge or allocate
        if (lk_valid_i) begin
            if (hit_any) begin
                if (st_q.ent[hit_idx].st == ENT_HELD) begin
                    st_d.hit_v    = 1'b1;
                    st_d.hit_tag  = lk_tag_i;
                    st_d.hit_data = st_q.ent[hit_idx].data;
                end
                for (int i = 0; i < ENTRIES; i++) begin
                    if (hit_vec[i] && st_d.ent[i].st != ENT_FREE) begin
                        st_d.ent[i].owners = st_d.ent[i].owners | tag_oh;
                    end
                end
            end else if (free_any) begin
                st_d.ent[free_idx].st       = ENT_WAIT;
                st_d.ent[free_idx].addr     = lk_addr_i;
                st_d.ent[free_idx].data     = '0;
                st_d.ent[free_idx].owners   = tag_oh;
                st_d.ent[free_idx].pend     = 1'b0;
                st_d.ent[free_idx].pend_tag = '0;
                st_d.req_v                  = 1'b1;
                st_d.req_addr               = lk_addr_i;
                st_d.req_id                 = free_idx;
            end
        end

        // a held line nobody tracks and nobody committed is discarded
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_d.ent[i].st == ENT_HELD && st_d.ent[i].owners == '0 && !st_d.ent[i].pend) begin
                st_d.ent[i]    = '0;
                st_d.ent[i].st = ENT_FREE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_valid_o    = st_q.hit_v;
    assign hit_tag_o      = st_q.hit_tag;
    assign hit_data_o     = st_q.hit_data;
    assign dn_req_valid_o = st_q.req_v;
    assign dn_req_addr_o  = st_q.req_addr;
    assign dn_req_id_o    = st_q.req_id;
    assign fwd_valid_o    = st_q.fwd_v;
    assign fwd_addr_o     = st_q.fwd_addr;
    assign fwd_data_o     = st_q.fwd_data;
    assign inst_valid_o   = st_q.inst_v;
    assign inst_addr_o    = st_q.inst_addr;
    assign inst_data_o    = st_q.inst_data;

    // R4: refusal only when no slot is left and nothing matched
    a_r4_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall_o |-> (&busy && !hit_any));

    // R2: a matching lookup never goes downstream
    a_r2_hit_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && hit_any) |=> !dn_req_valid_o);

    // R1: every outgoing request names a slot that is waiting on that line
    a_r1_request_owned: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid_o |-> (st_q.ent[dn_req_id_o].st == ENT_WAIT &&
                            st_q.ent[dn_req_id_o].addr == dn_req_addr_o));

    // R5: only a committed slot holding data is installed
    a_r5_install_committed: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> (st_q.ent[pick_idx].st == ENT_HELD && st_q.ent[pick_idx].pend));

    // R3: data for a waiting slot is forwarded next cycle
    a_r3_fill_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && st_q.ent[fill_id_i].st == ENT_WAIT) |=> fwd_valid_o);

endmodule

// File: tb/test_fsb_fill_buffer.sv
module test_fsb_fill_buffer;

    localparam int unsigned ENTRIES = 8;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned LINE_W  = 512;
    localparam int unsigned TAGS    = 16;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned TAG_W   = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                lk_valid_i = 1'b0;
    logic [ADDR_W-1:0]   lk_addr_i = '0;
    logic [TAG_W-1:0]    lk_tag_i = '0;
    logic                lk_stall_o;
    logic                hit_valid_o;
    logic [TAG_W-1:0]    hit_tag_o;
    logic [LINE_W-1:0]   hit_data_o;
    logic                dn_req_valid_o;
    logic [ADDR_W-1:0]   dn_req_addr_o;
    logic [IDX_W-1:0]    dn_req_id_o;
    logic                fill_valid_i = 1'b0;
    logic [IDX_W-1:0]    fill_id_i = '0;
    logic [LINE_W-1:0]   fill_data_i = '0;
    logic                fwd_valid_o;
    logic [ADDR_W-1:0]   fwd_addr_o;
    logic [LINE_W-1:0]   fwd_data_o;
    logic [TAGS-1:0]     commit_mask_i = '0;
    logic [TAGS-1:0]     squash_mask_i = '0;
    logic                inst_valid_o;
    logic [ADDR_W-1:0]   inst_addr_o;
    logic [LINE_W-1:0]   inst_data_o;

    always #2 clk = ~clk;   // 250 MHz

    fsb_fill_buffer #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .LINE_W  (LINE_W),
        .TAGS    (TAGS)
    ) i_fsb_fill_buffer (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_valid_i     (lk_valid_i),
        .lk_addr_i      (lk_addr_i),
        .lk_tag_i       (lk_tag_i),
        .lk_stall_o     (lk_stall_o),
        .hit_valid_o    (hit_valid_o),
        .hit_tag_o      (hit_tag_o),
        .hit_data_o     (hit_data_o),
        .dn_req_valid_o (dn_req_valid_o),
        .dn_req_addr_o  (dn_req_addr_o),
        .dn_req_id_o    (dn_req_id_o),
        .fill_valid_i   (fill_valid_i),
        .fill_id_i      (fill_id_i),
        .fill_data_i    (fill_data_i),
        .fwd_valid_o    (fwd_valid_o),
        .fwd_addr_o     (fwd_addr_o),
        .fwd_data_o     (fwd_data_o),
        .commit_mask_i  (commit_mask_i),
        .squash_mask_i  (squash_mask_i),
        .inst_valid_o   (inst_valid_o),
        .inst_addr_o    (inst_addr_o),
        .inst_data_o    (inst_data_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {16{a ^ 32'hC3A5_0000}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } hit_exp_t;

    // scoreboard queues, filled by the driver tasks
    logic [ADDR_W-1:0] q_req[$];
    logic [ADDR_W-1:0] q_fwd[$];
    logic [ADDR_W-1:0] q_inst[$];
    hit_exp_t          q_hit[$];
    logic [IDX_W-1:0]  id_map[logic [ADDR_W-1:0]];

    logic [ADDR_W-1:0] m_exp;
    hit_exp_t          m_hit;

    // monitor: registered outputs sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dn_req_valid_o) begin
                id_map[dn_req_addr_o] = dn_req_id_o;
                if (q_req.size() == 0) begin
                    chk(1'b0, "R1 unexpected downstream request", 64'(dn_req_addr_o), 64'h0);
                end else begin
                    m_exp = q_req.pop_front();
                    chk(dn_req_addr_o == m_exp, "R1 request address", 64'(dn_req_addr_o), 64'(m_exp));
                end
            end
            if (hit_valid_o) begin
                if (q_hit.size() == 0) begin
                    chk(1'b0, "R2 unexpected hit response", 64'(hit_tag_o), 64'h0);
                end else begin
                    m_hit = q_hit.pop_front();
                    chk(hit_tag_o == m_hit.tag && hit_data_o == line_of(m_hit.addr),
                        "R2 hit tag and data", {28'h0, hit_tag_o, hit_data_o[31:0]},
                        {28'h0, m_hit.tag, line_of(m_hit.addr)[31:0]});
                end
            end
            if (fwd_valid_o) begin
                if (q_fwd.size() == 0) begin
                    chk(1'b0, "R3 unexpected forward", 64'(fwd_addr_o), 64'h0);
                end else begin
                    m_exp = q_fwd.pop_front();
                    chk(fwd_addr_o == m_exp && fwd_data_o == line_of(m_exp),
                        "R3 forward line", 64'(fwd_addr_o), 64'(m_exp));
                end
            end
            if (inst_valid_o) begin
                if (q_inst.size() == 0) begin
                    chk(1'b0, "R6 unexpected install", 64'(inst_addr_o), 64'h0);
                end else begin
                    m_exp = q_inst.pop_front();
                    chk(inst_addr_o == m_exp && inst_data_o == line_of(m_exp),
                        "R5 R7 install order and data", 64'(inst_addr_o), 64'(m_exp));
                end
            end
        end
    end

    logic stall_seen;

    task automatic do_lookup(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
        @(negedge clk);
        lk_valid_i = 1'b1;
        lk_addr_i  = a;
        lk_tag_i   = t;
        #1;
        stall_seen = lk_stall_o;
        @(negedge clk);
        lk_valid_i = 1'b0;
    endtask

    task automatic lookup_miss(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
        q_req.push_back(a);
        do_lookup(a, t);
        chk(!stall_seen, "R4 no stall while a slot is free", 64'(stall_seen), 64'h0);
    endtask

    task automatic lookup_hit(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
        hit_exp_t h;
        h.tag  = t;
        h.addr = a;
        q_hit.push_back(h);
        do_lookup(a, t);
    endtask

    task automatic fill_line(input logic [ADDR_W-1:0] a);
        int w;
        w = 0;
        while (!id_map.exists(a) && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(id_map.exists(a), "R1 request id seen before fill", 64'(w), 64'h0);
        @(negedge clk);
        fill_valid_i = 1'b1;
        fill_id_i    = id_map.exists(a) ? id_map[a] : '0;
        fill_data_i  = line_of(a);
        q_fwd.push_back(a);
        @(negedge clk);
        fill_valid_i = 1'b0;
        if (id_map.exists(a)) id_map.delete(a);
    endtask

    task automatic pulse_commit(input logic [TAGS-1:0] m);
        @(negedge clk);
        commit_mask_i = m;
        @(negedge clk);
        commit_mask_i = '0;
    endtask

    task automatic pulse_squash(input logic [TAGS-1:0] m);
        @(negedge clk);
        squash_mask_i = m;
        @(negedge clk);
        squash_mask_i = '0;
    endtask

    task automatic drain(input string req);
        repeat (6) @(negedge clk);
        chk(q_req.size() == 0,  {req, " requests drained"}, 64'(q_req.size()), 64'h0);
        chk(q_hit.size() == 0,  {req, " hits drained"},     64'(q_hit.size()), 64'h0);
        chk(q_fwd.size() == 0,  {req, " forwards drained"}, 64'(q_fwd.size()), 64'h0);
        chk(q_inst.size() == 0, {req, " installs drained"}, 64'(q_inst.size()), 64'h0);
    endtask

    localparam logic [ADDR_W-1:0] LA = 32'h0000_1000;
    localparam logic [ADDR_W-1:0] LB = 32'h0000_2040;
    localparam logic [ADDR_W-1:0] LC = 32'h0000_3080;
    localparam logic [ADDR_W-1:0] LD = 32'h0001_0000;
    localparam logic [ADDR_W-1:0] LE = 32'h0002_0000;

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: idle after reset
        chk(!hit_valid_o && !dn_req_valid_o && !fwd_valid_o && !inst_valid_o && !lk_stall_o,
            "R8 outputs idle after reset",
            {59'h0, hit_valid_o, dn_req_valid_o, fwd_valid_o, inst_valid_o, lk_stall_o}, 64'h0);

        // R1 R2 R5: miss, fill held back, hit, commit installs, slot freed
        lookup_miss(LA, 4'd1);
        repeat (3) @(negedge clk);
        fill_line(LA);
        repeat (3) @(negedge clk);
        lookup_hit(LA, 4'd2);
        q_inst.push_back(LA);
        pulse_commit(TAGS'(1) << 1);
        drain("R5");

        // R6: squash before data, then squash after data
        lookup_miss(LA, 4'd3);
        pulse_squash(TAGS'(1) << 3);
        fill_line(LA);
        drain("R6");
        lookup_miss(LA, 4'd4);
        fill_line(LA);
        pulse_squash(TAGS'(1) << 4);
        drain("R6");
        lookup_miss(LA, 4'd5);   // slot was released
        fill_line(LA);
        pulse_squash(TAGS'(1) << 5);
        drain("R6");

        // R3: merge onto a waiting slot, first load squashed, second commits
        lookup_miss(LB, 4'd6);
        do_lookup(LB, 4'd7);
        fill_line(LB);
        pulse_squash(TAGS'(1) << 6);
        q_inst.push_back(LB);
        pulse_commit(TAGS'(1) << 7);
        drain("R3");

        // R5: commit arrives before the data
        lookup_miss(LC, 4'd8);
        pulse_commit(TAGS'(1) << 8);
        repeat (4) @(negedge clk);
        q_inst.push_back(LC);
        fill_line(LC);
        drain("R5");

        // R4: fill every slot, then a new line stalls
        for (int k = 0; k < 8; k++) lookup_miss(LD + 32'(k * 64), 4'(k));
        for (int k = 0; k < 8; k++) fill_line(LD + 32'(k * 64));
        do_lookup(LE, 4'd8);
        chk(stall_seen, "R4 stall when every slot is occupied", 64'(stall_seen), 64'h1);
        drain("R4");

        // R9: commit of an untracked tag changes nothing
        pulse_commit(TAGS'(1) << 9);
        repeat (4) @(negedge clk);
        lookup_hit(LD + 32'(3 * 64), 4'd10);
        drain("R9");

        // R7: three simultaneous commits install oldest tag first
        q_inst.push_back(LD + 32'(2 * 64));
        q_inst.push_back(LD + 32'(5 * 64));
        q_inst.push_back(LD + 32'(7 * 64));
        pulse_commit((TAGS'(1) << 7) | (TAGS'(1) << 2) | (TAGS'(1) << 5));
        drain("R7");

        // R4: retry after slots were freed is accepted
        lookup_miss(LE, 4'd8);
        drain("R4");

        // R6: squash everything left; unfilled slot drops on arrival
        pulse_squash((TAGS'(1) << 0) | (TAGS'(1) << 1) | (TAGS'(1) << 3) |
                     (TAGS'(1) << 4) | (TAGS'(1) << 6) | (TAGS'(1) << 8) |
                     (TAGS'(1) << 10));
        fill_line(LE);
        drain("R6");
        lookup_miss(LD, 4'd11);
        lookup_miss(LE, 4'd12);
        fill_line(LD);
        fill_line(LE);
        pulse_squash((TAGS'(1) << 11) | (TAGS'(1) << 12));
        drain("R6");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule